// File: doc/BRIEF.md
# Buffered ADC Trigger Generator

This block watches an up/down (triangle) PWM counter and raises A/D conversion start pulses when the counter reaches a programmed compare value. It does not own the counter. It receives the counter value and its direction, the limit value that bounds the slopes, and the crest and trough event strobes. A mode flag tells it whether the timer is running in complementary PWM operation. The counter, the PWM outputs and the converter itself live elsewhere.

There are two independent compare channels. Each channel holds a buffer register, which is written through a per-channel write strobe, and an active register, which is the value actually compared. Each channel also has two enables: one opens a window on the rising slope and the other opens a window on the falling slope. The two windows treat their endpoints differently. A shared 2-bit transfer-select field decides whether writes reach the active register at once, or whether the buffer is copied into the active register at the crest, at the trough, or at both. This lets new compare values take effect on the next half period.

Top module: `adctrg_top`

## Requirements
- R1: After a synchronous active-low reset, both trigger outputs are low and the buffer and active registers of both channels hold zero.
- R2: A channel raises its trigger output for one clock, one cycle after the clock edge at which the counter equals that channel's active register and the counter lies inside an enabled window.
- R3: The rising window applies when the up enable is set and the direction input is 0 (rising). It covers counter values from 0 up to the limit minus 1. A match at a counter value equal to the limit while rising gives no trigger. With a limit of 0 the rising window is empty.
- R4: The falling window applies when the down enable is set and the direction input is 1 (falling). It covers counter values from the limit down to 1. A match at 0 while falling gives no trigger.
- R5: While the complementary PWM mode input is 0, neither channel triggers.
- R6: A channel whose enables are both 0 never triggers. A channel with only the up enable set ignores matches on the falling slope, and a channel with only the down enable set ignores matches on the rising slope.
- R7: With transfer-select 00, a buffer write also loads the active register. The new value is compared from the next clock onward.
- R8: With transfer-select 10, a buffer write leaves the active register unchanged. The buffer is copied into the active register on a clock where the trough strobe is high, and the crest strobe causes no copy.
- R9: With transfer-select 01, the copy happens only on the crest strobe. With 11, the copy happens on either the crest strobe or the trough strobe.
- R10: A match that holds for several consecutive clocks produces only one trigger pulse. After at least one clock without a match, a new match produces a new pulse.
- R11: The two channels compare, copy and trigger independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current PWM counter value |
| cnt_down | input | 1 | Counter direction, 1 = falling, 0 = rising |
| limit_val | input | CNT_W | Slope limit value bounding the windows |
| crest_evt | input | 1 | Counter crest strobe |
| trough_evt | input | 1 | Counter trough strobe |
| comp_pwm_en | input | 1 | Complementary PWM mode active |
| up_en | input | NCH | Per-channel rising-window enable |
| dn_en | input | NCH | Per-channel falling-window enable |
| xfer_sel | input | 2 | Buffer-to-active transfer select (00 direct, 01 crest, 10 trough, 11 both) |
| buf_wr | input | NCH | Per-channel buffer write strobe |
| buf_wdata | input | CNT_W | Buffer write data |
| trig | output | NCH | One-clock trigger pulse per channel |

## Verification
The assertions assume that the direction input agrees with the counter's slope, and that the crest and trough strobes are never high on the same clock. They also assume that the inputs are settled at each rising edge, because matches and copies are taken from the values sampled there. The bench drives every input just after a clock edge. It applies a crest strobe only on a rising-to-falling count and a trough strobe only at count 0, never both together. It keeps counter values within the limit except where a boundary case calls for the limit itself.

// File: rtl/adctrg_pkg.sv
// Shared types for the buffered ADC trigger generator.
// Assumes: transfer-select is a 2-bit field with the four codes below.
package adctrg_pkg;
    typedef enum logic [1:0] {
        XF_DIRECT = 2'b00,
        XF_CREST  = 2'b01,
        XF_TROUGH = 2'b10,
        XF_BOTH   = 2'b11
    } xfer_sel_e;
endpackage

// File: rtl/adctrg_xfer_ctl.sv
// Decodes the transfer-select field and event strobes into a load request
// shared by every channel, plus a flag for direct (unbuffered) writes.
// Assumes: crest and trough strobes are single-cycle and never coincide.
module adctrg_xfer_ctl
    import adctrg_pkg::*;
(
    input  logic [1:0] xfer_sel,
    input  logic       crest_evt,
    input  logic       trough_evt,
    output logic       direct_wr,
    output logic       load_req
);
    xfer_sel_e sel;

    // Decode the select code into direct-write and load-request controls.
    always_comb begin
        sel       = xfer_sel_e'(xfer_sel);
        direct_wr = 1'b0;
        load_req  = 1'b0;
        unique case (sel)
            XF_DIRECT: direct_wr = 1'b1;
            XF_CREST:  load_req  = crest_evt;
            XF_TROUGH: load_req  = trough_evt;
            XF_BOTH:   load_req  = crest_evt | trough_evt;
            default:   load_req  = 1'b0;
        endcase
    end
endmodule

// File: rtl/adctrg_window.sv
// Computes the direction-qualified compare windows shared by all channels.
// Rising window: counter in [0, limit-1]; falling window: counter in [1, limit].
// Assumes: cnt_down reflects the slope of the counter in the same cycle.
module adctrg_window #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] limit_val,
    input  logic             comp_pwm_en,
    output logic             in_up_win,
    output logic             in_dn_win
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    // Qualify each slope window with mode and direction.
    always_comb begin
        in_up_win = comp_pwm_en && !cnt_down && (cnt_val < limit_val);
        in_dn_win = comp_pwm_en &&  cnt_down && (cnt_val != ZERO)
                    && (cnt_val <= limit_val);
    end
endmodule

// File: rtl/adctrg_chan.sv
// One compare channel: buffer register, active register, window-gated
// equality match and a rising-edge trigger pulse registered one cycle later.
// Assumes: load_req and direct_wr come from adctrg_xfer_ctl and are exclusive.
module adctrg_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             in_up_win,
    input  logic             in_dn_win,
    input  logic             up_en,
    input  logic             dn_en,
    input  logic             direct_wr,
    input  logic             load_req,
    input  logic             buf_wr,
    input  logic [CNT_W-1:0] buf_wdata,
    output logic [CNT_W-1:0] buf_q,
    output logic [CNT_W-1:0] act_q,
    output logic             trig
);
    logic match;
    logic match_q;

    // Match only when the counter hits the active value inside an enabled window.
    always_comb begin
        match = (cnt_val == act_q) && ((up_en && in_up_win) || (dn_en && in_dn_win));
    end

    // Buffer write path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (buf_wr) begin
            buf_q <= buf_wdata;
        end
    end

    // Active register: direct write or buffered copy on the selected event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (direct_wr && buf_wr) begin
            act_q <= buf_wdata;
        end else if (load_req) begin
            act_q <= buf_q;
        end
    end

    // Register the match and emit one pulse per match episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            trig    <= 1'b0;
        end else begin
            match_q <= match;
            trig    <= match && !match_q;
        end
    end
endmodule

// File: rtl/adctrg_top.sv
// Buffered ADC trigger generator top: shared window and transfer decode,
// one compare channel per trigger output.
// Assumes: external counter drives cnt_val/cnt_down and the event strobes.
module adctrg_top #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] limit_val,
    input  logic             crest_evt,
    input  logic             trough_evt,
    input  logic             comp_pwm_en,
    input  logic [NCH-1:0]   up_en,
    input  logic [NCH-1:0]   dn_en,
    input  logic [1:0]       xfer_sel,
    input  logic [NCH-1:0]   buf_wr,
    input  logic [CNT_W-1:0] buf_wdata,
    output logic [NCH-1:0]   trig
);
    localparam int FLAT_W = NCH * CNT_W;

    logic              in_up_win;
    logic              in_dn_win;
    logic              direct_wr;
    logic              load_req;
    logic [FLAT_W-1:0] act_flat;
    logic [FLAT_W-1:0] buf_flat;

    adctrg_window #(.CNT_W(CNT_W)) u_win (
        .cnt_val     (cnt_val),
        .cnt_down    (cnt_down),
        .limit_val   (limit_val),
        .comp_pwm_en (comp_pwm_en),
        .in_up_win   (in_up_win),
        .in_dn_win   (in_dn_win)
    );

    adctrg_xfer_ctl u_xfer (
        .xfer_sel   (xfer_sel),
        .crest_evt  (crest_evt),
        .trough_evt (trough_evt),
        .direct_wr  (direct_wr),
        .load_req   (load_req)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        adctrg_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_val   (cnt_val),
            .in_up_win (in_up_win),
            .in_dn_win (in_dn_win),
            .up_en     (up_en[g]),
            .dn_en     (dn_en[g]),
            .direct_wr (direct_wr),
            .load_req  (load_req),
            .buf_wr    (buf_wr[g]),
            .buf_wdata (buf_wdata),
            .buf_q     (buf_flat[g*CNT_W +: CNT_W]),
            .act_q     (act_flat[g*CNT_W +: CNT_W]),
            .trig      (trig[g])
        );
    end
endmodule

// File: rtl/adctrg_chk.sv
// Assertion checker for adctrg_top, attached by bind below.
// Assumes: inputs are stable around each rising clock edge.
module adctrg_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CNT_W-1:0]     cnt_val,
    input logic                 cnt_down,
    input logic [CNT_W-1:0]     limit_val,
    input logic                 crest_evt,
    input logic                 trough_evt,
    input logic                 comp_pwm_en,
    input logic [NCH-1:0]       up_en,
    input logic [NCH-1:0]       dn_en,
    input logic [1:0]           xfer_sel,
    input logic [NCH-1:0]       buf_wr,
    input logic [CNT_W-1:0]     buf_wdata,
    input logic [NCH-1:0]       trig,
    input logic [NCH*CNT_W-1:0] act_flat,
    input logic [NCH*CNT_W-1:0] buf_flat
);
    // R1: reset clears the trigger outputs.
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (trig == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R10: a pulse never lasts two cycles.
        a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            trig[i] |=> !trig[i]);

        // R5: mode off blocks triggers.
        a_r5_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
            !comp_pwm_en |=> !trig[i]);

        // R6: no enables, no triggers.
        a_r6_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (!up_en[i] && !dn_en[i]) |=> !trig[i]);

        // R2 R3 R4: every pulse follows an in-window equality match.
        a_r2_match_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            trig[i] |-> ($past(cnt_val) == $past(act_flat[i*CNT_W +: CNT_W]))
                && (($past(up_en[i]) && !$past(cnt_down)
                     && ($past(cnt_val) < $past(limit_val)))
                 || ($past(dn_en[i]) && $past(cnt_down)
                     && ($past(cnt_val) != '0)
                     && ($past(cnt_val) <= $past(limit_val)))));

        // R7: direct write lands in the active register.
        a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_sel == 2'b00 && buf_wr[i])
            |=> (act_flat[i*CNT_W +: CNT_W] == $past(buf_wdata)));

        // R8: trough copy under select 10.
        a_r8_trough_copy: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_sel == 2'b10 && trough_evt)
            |=> (act_flat[i*CNT_W +: CNT_W] == $past(buf_flat[i*CNT_W +: CNT_W])));

        // R9: crest copy under select 01.
        a_r9_crest_copy: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_sel == 2'b01 && crest_evt)
            |=> (act_flat[i*CNT_W +: CNT_W] == $past(buf_flat[i*CNT_W +: CNT_W])));
    end
endmodule

bind adctrg_top adctrg_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_val     (cnt_val),
    .cnt_down    (cnt_down),
    .limit_val   (limit_val),
    .crest_evt   (crest_evt),
    .trough_evt  (trough_evt),
    .comp_pwm_en (comp_pwm_en),
    .up_en       (up_en),
    .dn_en       (dn_en),
    .xfer_sel    (xfer_sel),
    .buf_wr      (buf_wr),
    .buf_wdata   (buf_wdata),
    .trig        (trig),
    .act_flat    (act_flat),
    .buf_flat    (buf_flat)
);

// File: tb/adctrg_top_tb.sv
module adctrg_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int NCH   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             cnt_down = 1'b0;
    logic [CNT_W-1:0] limit_val = '0;
    logic             crest_evt = 1'b0;
    logic             trough_evt = 1'b0;
    logic             comp_pwm_en = 1'b0;
    logic [NCH-1:0]   up_en = '0;
    logic [NCH-1:0]   dn_en = '0;
    logic [1:0]       xfer_sel = 2'b00;
    logic [NCH-1:0]   buf_wr = '0;
    logic [CNT_W-1:0] buf_wdata = '0;
    logic [NCH-1:0]   trig;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adctrg_top #(.CNT_W(CNT_W), .NCH(NCH)) u_dut (
        .clk (clk), .rst_n (rst_n), .cnt_val (cnt_val), .cnt_down (cnt_down),
        .limit_val (limit_val), .crest_evt (crest_evt), .trough_evt (trough_evt),
        .comp_pwm_en (comp_pwm_en), .up_en (up_en), .dn_en (dn_en),
        .xfer_sel (xfer_sel), .buf_wr (buf_wr), .buf_wdata (buf_wdata),
        .trig (trig)
    );

    // Advance one clock; inputs change 1 time unit after the edge.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_trig(input logic [NCH-1:0] exp, input string tag);
        n_checks++;
        if (trig !== exp) begin
            n_fail++;
            $display("FAIL %s: trig actual=%b expected=%b", tag, trig, exp);
        end
    endtask

    // Present counter value/direction for one clock, then check the pulse.
    task automatic step(input int v, input logic dn, input logic [NCH-1:0] exp,
                        input string tag);
        cnt_val = CNT_W'(v);
        cnt_down = dn;
        cyc();
        expect_trig(exp, tag);
    endtask

    // Write buffer(s); counter parked at a value no test compares against.
    task automatic wr(input logic [NCH-1:0] mask, input int v);
        cnt_val = CNT_W'(99);
        cnt_down = 1'b0;
        buf_wr = mask;
        buf_wdata = CNT_W'(v);
        cyc();
        buf_wr = '0;
    endtask

    task automatic idle();
        cnt_val = CNT_W'(99);
        cnt_down = 1'b0;
        cyc();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        expect_trig(2'b00, "R1 trig low in reset");
        rst_n = 1'b1;
        cyc();
        expect_trig(2'b00, "R1 trig low after reset");
        comp_pwm_en = 1'b1;
        limit_val = 16'd10;
        up_en = 2'b11;
        step(0, 1'b0, 2'b11, "R1 active regs zero");
        step(1, 1'b0, 2'b00, "R1 pulse ends");
    endtask

    task automatic t_up_window();
        up_en = 2'b01; dn_en = 2'b00; xfer_sel = 2'b00;
        wr(2'b01, 5);
        step(5, 1'b0, 2'b01, "R2 match rising");
        step(6, 1'b0, 2'b00, "R2 one-cycle pulse");
        wr(2'b01, 10);
        step(10, 1'b0, 2'b00, "R3 limit excluded rising");
        wr(2'b01, 9);
        step(9, 1'b0, 2'b01, "R3 limit-1 included");
        idle();
        limit_val = 16'd0;
        wr(2'b01, 0);
        step(0, 1'b0, 2'b00, "R3 empty window limit 0");
        limit_val = 16'd10;
        idle();
        step(0, 1'b0, 2'b01, "R3 zero included rising");
        idle();
    endtask

    task automatic t_dn_window();
        up_en = 2'b00; dn_en = 2'b01;
        wr(2'b01, 10);
        step(10, 1'b1, 2'b01, "R4 limit included falling");
        idle();
        wr(2'b01, 0);
        step(0, 1'b1, 2'b00, "R4 zero excluded falling");
        wr(2'b01, 1);
        step(1, 1'b1, 2'b01, "R4 one included falling");
        step(1, 1'b0, 2'b00, "R6 down-only ignores rising");
        idle();
        up_en = 2'b01; dn_en = 2'b00;
        step(1, 1'b1, 2'b00, "R6 up-only ignores falling");
        idle();
    endtask

    task automatic t_gating();
        up_en = 2'b01; dn_en = 2'b01;
        wr(2'b01, 4);
        comp_pwm_en = 1'b0;
        step(4, 1'b0, 2'b00, "R5 mode off blocks");
        comp_pwm_en = 1'b1;
        idle();
        up_en = 2'b00; dn_en = 2'b00;
        step(4, 1'b0, 2'b00, "R6 no enables rising");
        idle();
        step(4, 1'b1, 2'b00, "R6 no enables falling");
        idle();
    endtask

    task automatic t_direct();
        up_en = 2'b01; dn_en = 2'b00; xfer_sel = 2'b00;
        wr(2'b01, 3);
        step(3, 1'b0, 2'b01, "R7 direct write effective next cycle");
        idle();
    endtask

    task automatic t_trough();
        up_en = 2'b01; dn_en = 2'b00; limit_val = 16'd10;
        xfer_sel = 2'b00;
        wr(2'b01, 3);
        xfer_sel = 2'b10;
        wr(2'b01, 7);
        step(7, 1'b0, 2'b00, "R8 buffered write not active");
        step(3, 1'b0, 2'b01, "R8 old value still active");
        crest_evt = 1'b1;
        step(8, 1'b1, 2'b00, "R8 crest no match");
        crest_evt = 1'b0;
        step(7, 1'b0, 2'b00, "R8 crest does not copy");
        trough_evt = 1'b1;
        step(0, 1'b1, 2'b00, "R8 trough no match");
        trough_evt = 1'b0;
        step(7, 1'b0, 2'b01, "R8 trough copied");
        idle();
    endtask

    task automatic t_crest();
        up_en = 2'b01; dn_en = 2'b00; limit_val = 16'd20;
        xfer_sel = 2'b01;
        wr(2'b01, 12);
        trough_evt = 1'b1;
        step(0, 1'b1, 2'b00, "R9 trough in crest mode");
        trough_evt = 1'b0;
        step(12, 1'b0, 2'b00, "R9 trough does not copy");
        crest_evt = 1'b1;
        step(20, 1'b1, 2'b00, "R9 crest no match");
        crest_evt = 1'b0;
        step(12, 1'b0, 2'b01, "R9 crest copied");
        idle();
        xfer_sel = 2'b11;
        wr(2'b01, 4);
        trough_evt = 1'b1;
        step(0, 1'b1, 2'b00, "R9 both-mode trough");
        trough_evt = 1'b0;
        step(4, 1'b0, 2'b01, "R9 both-mode trough copied");
        wr(2'b01, 6);
        crest_evt = 1'b1;
        step(20, 1'b1, 2'b00, "R9 both-mode crest");
        crest_evt = 1'b0;
        step(6, 1'b0, 2'b01, "R9 both-mode crest copied");
        idle();
        xfer_sel = 2'b00;
    endtask

    task automatic t_hold();
        up_en = 2'b01; dn_en = 2'b00; limit_val = 16'd10;
        wr(2'b01, 5);
        step(5, 1'b0, 2'b01, "R10 first match pulses");
        step(5, 1'b0, 2'b00, "R10 held match no repeat");
        step(5, 1'b0, 2'b00, "R10 still held");
        step(6, 1'b0, 2'b00, "R10 mismatch");
        step(5, 1'b0, 2'b01, "R10 re-armed");
        idle();
    endtask

    task automatic t_indep();
        up_en = 2'b11; dn_en = 2'b00; limit_val = 16'd10; xfer_sel = 2'b00;
        wr(2'b01, 5);
        wr(2'b10, 8);
        step(5, 1'b0, 2'b01, "R11 channel A alone");
        step(8, 1'b0, 2'b10, "R11 channel B alone");
        xfer_sel = 2'b10;
        wr(2'b10, 2);
        trough_evt = 1'b1;
        step(0, 1'b1, 2'b00, "R11 trough");
        trough_evt = 1'b0;
        step(5, 1'b0, 2'b01, "R11 channel A kept");
        step(2, 1'b0, 2'b10, "R11 channel B copied");
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_up_window();
        t_dn_window();
        t_gating();
        t_direct();
        t_trough();
        t_crest();
        t_hold();
        t_indep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule